// File: doc/BRIEF.md
# Programmable Video Clock Divider

The block takes one dot clock and derives a video clock (VCLK), a reference clock (RCLK) and a shift clock (SCLK) from it. SCLK runs at the RCLK ratio but is suppressed while the internal blank is active. A single shared 6-bit counter, clocked by the dot clock, supplies every divided output. An 8-bit control register is loaded on a write strobe in the dot-clock domain. It selects a power-of-two ratio for VCLK and for RCLK/SCLK, and it holds the SCLK enable.

The internal blank comes from one of two active-low inputs, chosen by a mode pin. The VGA-port blank is registered on the rising dot-clock edge. The system blank is registered on the falling edge of VCLK. SCLK is gated by a small state machine clocked on the falling edge of RCLK, with states `SG_STOP` and `SG_RUN`. The transition `SG_STOP -> SG_RUN` is taken when SCLK is enabled and blank is inactive. The transition `SG_RUN -> SG_STOP` is taken when SCLK is disabled or blank is active. Because the gate only moves while RCLK is low, every SCLK pulse is a complete RCLK high phase.

A second state machine in the dot-clock domain controls the counter. It has states `CNT_RUN` (count up) and `CNT_HELD` (counter held at zero). A register write whose low seven bits equal 0x3F takes `CNT_RUN -> CNT_HELD`. Any other write takes `CNT_HELD -> CNT_RUN`.

Top module: `vcd_top`

## Requirements
- R1: Register bits 5..3 select VCLK. Code c in 0..6 gives VCLK = dot clock / 2^c, where code 0 is the dot clock itself. Code 7 (111) holds VCLK at 1.
- R2: Register bits 2..0 select RCLK with the same encoding as R1. Code 7 holds both RCLK and SCLK at 0.
- R3: Register bit 6 enables SCLK when 1; when 0, SCLK is held low. The change takes effect at the next falling edge of RCLK. Register bit 7 has no effect on any output.
- R4: A write with bits 6..0 = 0x3F holds the counter at zero, with VCLK = 1, RCLK = 0 and SCLK = 0. After the next write releases it, the counter starts from zero. A divide-by-2^n output therefore first rises on the 2^(n-1)-th dot-clock rising edge after the releasing write edge.
- R5: With SCLK enabled and blank inactive, SCLK toggles at exactly the RCLK rate. SCLK is never high while RCLK is low.
- R6: With the mode pin = 1, the internal blank follows the VGA blank input, registered on the rising dot-clock edge. With the mode pin = 0, it follows the system blank input, registered only on falling VCLK edges, so a held VCLK freezes it. Both inputs are active low, and the unselected input has no effect.
- R7: When blank asserts or deasserts, SCLK stops or restarts only at a falling edge of RCLK. Every SCLK high pulse lasts exactly one full RCLK high phase.
- R8: Asynchronous reset clears the register to 0x00 and the counter to 0, stops the SCLK gate and makes the blank registers inactive. After reset, VCLK and RCLK equal the dot clock and SCLK is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dot_clk | input | 1 | Dot clock, source of all divided outputs |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe, sampled on rising dot_clk |
| cfg_wdata | input | 8 | Register write value |
| vga_mode | input | 1 | Blank source select: 1 = VGA blank, 0 = system blank |
| vga_blank_n | input | 1 | VGA-port blank, active low |
| sys_blank_n | input | 1 | System blank, active low |
| vclk_o | output | 1 | Divided video clock |
| rclk_o | output | 1 | Divided reference clock |
| sclk_o | output | 1 | Shift clock, RCLK gated by blank and enable |

## Verification
Suppose the counter state machine sits in the wrong state. The counter then stops, or fails to restart from zero, and the first rising edge of a divided output lands on the wrong dot-clock edge, at most 2^(n-1) cycles after the releasing write. A gate state that is wrong shows up within one RCLK period, as an SCLK pulse during blank, a missing pulse, or a pulse shorter than the RCLK high phase. A blank registered on the wrong edge or from the wrong input changes the SCLK pulse count within one VCLK period. The bench therefore checks edge counts over fixed windows, exact edge positions after a counter release, and the width of every SCLK pulse.

// File: rtl/vcd_pkg.sv
`timescale 1ns/1ps
package vcd_pkg;

    // ratio select field width and the reserved hold code
    localparam int SEL_W = 3;
    localparam logic [SEL_W-1:0] SEL_HOLD = '1;

    // control register image without the ignored top bit
    typedef struct packed {
        logic             sclk_en;  // bit 6
        logic [SEL_W-1:0] vsel;     // bits 5..3
        logic [SEL_W-1:0] rsel;     // bits 2..0
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);
    localparam logic [CFG_W-1:0] CFG_CLEAR_ALL = 7'h3F;

    typedef enum logic {
        CNT_RUN  = 1'b0,
        CNT_HELD = 1'b1
    } cnt_state_e;

    typedef enum logic {
        SG_STOP = 1'b0,
        SG_RUN  = 1'b1
    } gate_state_e;

endpackage

// File: rtl/vcd_cfg_ctrl.sv
`timescale 1ns/1ps
module vcd_cfg_ctrl
    import vcd_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg,
    output logic [CNT_W-1:0] cnt
);

    cnt_state_e       st_q, st_d;
    cfg_t             cfg_q, cfg_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // next register image and counter-control state
    always_comb begin
        st_d  = st_q;
        cfg_d = cfg_q;
        if (we) begin
            cfg_d = cfg_t'(wdata);
            if (wdata == CFG_CLEAR_ALL) begin
                st_d = CNT_HELD;
            end else begin
                st_d = CNT_RUN;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= CNT_RUN;
            cfg_q <= '0;
        end else begin
            st_q  <= st_d;
            cfg_q <= cfg_d;
        end
    end

    // counter action per state
    always_comb begin
        cnt_d = cnt_q;
        unique case (st_q)
            CNT_HELD: cnt_d = '0;
            CNT_RUN:  cnt_d = cnt_q + 1'b1;
            default:  cnt_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cfg = cfg_q;
    assign cnt = cnt_q;

    // R4: a clear-all write empties the counter two edges later
    p_clear_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wdata == CFG_CLEAR_ALL) |-> ##2 (cnt_q == '0));

    // R1: while running the counter advances by one per dot clock
    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CNT_RUN) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/vcd_ratio_mux.sv
`timescale 1ns/1ps
module vcd_ratio_mux
    import vcd_pkg::*;
#(
    parameter int CNT_W    = 6,
    parameter bit HOLD_LVL = 1'b0
) (
    input  logic             clk_in,
    input  logic [CNT_W-1:0] cnt,
    input  logic [SEL_W-1:0] sel,
    output logic             clk_out
);

    localparam int TAPS = 1 << SEL_W;

    logic [TAPS-1:0] taps;

    assign taps[0] = clk_in;

    // tap i is counter bit i-1 (divide by 2^i); unused and hold taps are constant
    for (genvar i = 1; i < TAPS; i++) begin : g_tap
        if (i <= CNT_W && i != TAPS - 1) begin : g_cnt
            assign taps[i] = cnt[i-1];
        end else begin : g_hold
            assign taps[i] = HOLD_LVL;
        end
    end

    assign clk_out = taps[sel];

endmodule

// File: rtl/vcd_blank_src.sv
`timescale 1ns/1ps
module vcd_blank_src (
    input  logic clk,
    input  logic vclk,
    input  logic rst_n,
    input  logic vga_mode,
    input  logic vga_blank_n,
    input  logic sys_blank_n,
    output logic blank_act
);

    logic vga_q;
    logic sys_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vga_q <= 1'b1;
        end else begin
            vga_q <= vga_blank_n;
        end
    end

    // system blank is taken on the falling edge of the divided video clock
    always_ff @(negedge vclk or negedge rst_n) begin
        if (!rst_n) begin
            sys_q <= 1'b1;
        end else begin
            sys_q <= sys_blank_n;
        end
    end

    assign blank_act = vga_mode ? !vga_q : !sys_q;

    // R6: in VGA mode a low blank input shows up as active blank one edge later
    p_vga_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vga_mode && $past(vga_mode) && !$past(vga_blank_n)) |-> blank_act);

endmodule

// File: rtl/vcd_sclk_gate.sv
`timescale 1ns/1ps
module vcd_sclk_gate
    import vcd_pkg::*;
(
    input  logic rclk,
    input  logic rst_n,
    input  logic sclk_en,
    input  logic blank_act,
    output logic sclk
);

    gate_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SG_STOP: if (sclk_en && !blank_act) st_d = SG_RUN;
            SG_RUN:  if (!sclk_en || blank_act) st_d = SG_STOP;
            default: st_d = SG_STOP;
        endcase
    end

    // gate moves only at a falling RCLK edge, so RCLK is low whenever it changes
    always_ff @(negedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SG_STOP;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        sclk = rclk && (st_q == SG_RUN);
    end

endmodule

// File: rtl/vcd_top.sv
`timescale 1ns/1ps
module vcd_top
    import vcd_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic       dot_clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    input  logic       vga_mode,
    input  logic       vga_blank_n,
    input  logic       sys_blank_n,
    output logic       vclk_o,
    output logic       rclk_o,
    output logic       sclk_o
);

    cfg_t             cfg;
    logic [CNT_W-1:0] cnt;
    logic             blank_act;
    logic             unused_cfg_msb;

    assign unused_cfg_msb = cfg_wdata[7];

    vcd_cfg_ctrl #(.CNT_W(CNT_W)) u_cfg (
        .clk   (dot_clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata[CFG_W-1:0]),
        .cfg   (cfg),
        .cnt   (cnt)
    );

    vcd_ratio_mux #(.CNT_W(CNT_W), .HOLD_LVL(1'b1)) u_vmux (
        .clk_in  (dot_clk),
        .cnt     (cnt),
        .sel     (cfg.vsel),
        .clk_out (vclk_o)
    );

    vcd_ratio_mux #(.CNT_W(CNT_W), .HOLD_LVL(1'b0)) u_rmux (
        .clk_in  (dot_clk),
        .cnt     (cnt),
        .sel     (cfg.rsel),
        .clk_out (rclk_o)
    );

    vcd_blank_src u_blank (
        .clk         (dot_clk),
        .vclk        (vclk_o),
        .rst_n       (rst_n),
        .vga_mode    (vga_mode),
        .vga_blank_n (vga_blank_n),
        .sys_blank_n (sys_blank_n),
        .blank_act   (blank_act)
    );

    vcd_sclk_gate u_gate (
        .rclk      (rclk_o),
        .rst_n     (rst_n),
        .sclk_en   (cfg.sclk_en),
        .blank_act (blank_act),
        .sclk      (sclk_o)
    );

    // R1: the VCLK hold code keeps the output high
    p_vhold_r1: assert property (@(posedge dot_clk) disable iff (!rst_n)
        (cfg.vsel == SEL_HOLD) |-> vclk_o);

    // R2: the RCLK hold code keeps both RCLK and SCLK low
    p_rhold_r2: assert property (@(posedge dot_clk) disable iff (!rst_n)
        (cfg.rsel == SEL_HOLD) |-> (!rclk_o && !sclk_o));

    // R5: SCLK is never high outside an RCLK high phase
    p_sclk_within_r5: assert property (@(posedge dot_clk) disable iff (!rst_n)
        sclk_o |-> rclk_o);

endmodule

// File: tb/vcd_top_tb_top.sv
`timescale 1ns/1ps
module vcd_top_tb_top;

    logic       dot_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       vga_mode = 1'b0;
    logic       vga_blank_n = 1'b1;
    logic       sys_blank_n = 1'b1;
    logic       vclk_o, rclk_o, sclk_o;

    always #5 dot_clk = ~dot_clk;

    vcd_top dut_i (
        .dot_clk     (dot_clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .vga_mode    (vga_mode),
        .vga_blank_n (vga_blank_n),
        .sys_blank_n (sys_blank_n),
        .vclk_o      (vclk_o),
        .rclk_o      (rclk_o),
        .sclk_o      (sclk_o)
    );

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    bit  counting = 1'b0;
    int  v_edges, r_edges, s_edges;
    bit  pulse_chk = 1'b0;
    int  pulses = 0;
    int  runts = 0;
    realtime t_rise = 0.0;

    always @(posedge vclk_o) if (counting) v_edges++;
    always @(posedge rclk_o) if (counting) r_edges++;
    always @(posedge sclk_o) begin
        if (counting) s_edges++;
        t_rise = $realtime;
    end
    always @(negedge sclk_o) begin
        if (pulse_chk) begin
            pulses++;
            if (($realtime - t_rise) < 19.5 || ($realtime - t_rise) > 20.5) runts++;
        end
    end

    // stimulus/expectation table: config, VCLK, RCLK, SCLK rising edges per 256 dot cycles
    localparam int NV = 8;
    localparam logic [7:0] VEC_CFG [NV] = '{8'h00, 8'h49, 8'h53, 8'h64, 8'h75, 8'h2E, 8'h7F, 8'hCB};
    localparam int VEC_V [NV] = '{256, 128, 64, 16, 4,   8, 0, 128};
    localparam int VEC_R [NV] = '{256, 128, 32, 16, 8,   4, 0,  32};
    localparam int VEC_S [NV] = '{  0, 128, 32, 16, 8,   0, 0,  32};
    localparam string VEC_TAG [NV] = '{"R1/R2/R3", "R1/R2/R5", "R1/R2/R5", "R1/R2/R5",
                                       "R1/R2/R5", "R1/R2/R3", "R1/R2", "R3 bit7"};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_count(input string req, input int act, input int exp);
        bit ok;
        if (exp == 0) ok = (act == 0);
        else          ok = (act >= exp - 1) && (act <= exp + 1);
        check(ok, req, act, exp);
    endtask

    task automatic cfg_write(input logic [7:0] d);
        @(negedge dot_clk);
        cfg_we    = 1'b1;
        cfg_wdata = d;
        @(posedge dot_clk);
        #1 cfg_we = 1'b0;
    endtask

    task automatic count_window(input int cycles);
        @(posedge dot_clk);
        #2;
        v_edges = 0; r_edges = 0; s_edges = 0;
        counting = 1'b1;
        repeat (cycles) @(posedge dot_clk);
        #2 counting = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        finish_run();
    end

    initial begin
        // R8: reset state
        repeat (3) @(negedge dot_clk);
        rst_n = 1'b1;
        @(posedge dot_clk); #2;
        check(vclk_o == 1'b1, "R8 vclk follows dot clock (high)", int'(vclk_o), 1);
        check(rclk_o == 1'b1, "R8 rclk follows dot clock (high)", int'(rclk_o), 1);
        check(sclk_o == 1'b0, "R8 sclk low after reset", int'(sclk_o), 0);
        @(negedge dot_clk); #2;
        check(vclk_o == 1'b0, "R8 vclk follows dot clock (low)", int'(vclk_o), 0);

        // table of ratio patterns, system blank inactive
        for (int i = 0; i < NV; i++) begin
            cfg_write(8'h3F);
            repeat (2) @(posedge dot_clk);
            cfg_write(VEC_CFG[i]);
            repeat (140) @(posedge dot_clk);
            count_window(256);
            check_count({VEC_TAG[i], " vclk edges"}, v_edges, VEC_V[i]);
            check_count({VEC_TAG[i], " rclk edges"}, r_edges, VEC_R[i]);
            check_count({VEC_TAG[i], " sclk edges"}, s_edges, VEC_S[i]);
        end

        // R4: clear-all hold levels and release phase
        cfg_write(8'h3F);
        repeat (4) @(posedge dot_clk);
        begin
            int bad = 0;
            for (int k = 0; k < 16; k++) begin
                @(negedge dot_clk); #2;
                if (vclk_o !== 1'b1 || rclk_o !== 1'b0 || sclk_o !== 1'b0) bad++;
                @(posedge dot_clk); #2;
                if (vclk_o !== 1'b1 || rclk_o !== 1'b0 || sclk_o !== 1'b0) bad++;
            end
            check(bad == 0, "R4 hold levels vclk=1 rclk=0 sclk=0", bad, 0);
        end
        cfg_write(8'h19);   // vclk /8, rclk /2, sclk off
        #1;
        check(vclk_o == 1'b0 && rclk_o == 1'b0, "R4 outputs low at release edge",
              int'({vclk_o, rclk_o}), 0);
        @(posedge dot_clk); #2;
        check(rclk_o == 1'b1, "R4 rclk /2 rises on first edge", int'(rclk_o), 1);
        check(vclk_o == 1'b0, "R4 vclk /8 low after edge 1", int'(vclk_o), 0);
        repeat (2) @(posedge dot_clk);
        #2;
        check(vclk_o == 1'b0, "R4 vclk /8 low after edge 3", int'(vclk_o), 0);
        @(posedge dot_clk); #2;
        check(vclk_o == 1'b1, "R4 vclk /8 rises on edge 4", int'(vclk_o), 1);

        // R6: system blank gates SCLK, RCLK keeps running
        vga_mode = 1'b0;
        cfg_write(8'h52);
        sys_blank_n = 1'b0;
        repeat (20) @(posedge dot_clk);
        count_window(64);
        check_count("R6 sclk stopped by system blank", s_edges, 0);
        check_count("R6 rclk runs during blank", r_edges, 16);
        sys_blank_n = 1'b1;
        repeat (20) @(posedge dot_clk);
        count_window(64);
        check_count("R6 sclk resumes after system blank", s_edges, 16);

        // R7: blank toggled at awkward times, every SCLK pulse must be whole
        pulses = 0; runts = 0;
        pulse_chk = 1'b1;
        for (int k = 0; k < 40; k++) begin
            #(37 + (k * 13) % 29);
            sys_blank_n = ~sys_blank_n;
        end
        sys_blank_n = 1'b1;
        repeat (20) @(posedge dot_clk);
        pulse_chk = 1'b0;
        check(runts == 0, "R7 no truncated sclk pulse", runts, 0);
        check(pulses > 0, "R7 sclk pulses observed", pulses, 1);

        // R6: VGA mode selects VGA blank and ignores system blank
        vga_mode = 1'b1;
        vga_blank_n = 1'b0;
        repeat (20) @(posedge dot_clk);
        count_window(64);
        check_count("R6 sclk stopped by VGA blank", s_edges, 0);
        vga_blank_n = 1'b1;
        sys_blank_n = 1'b0;
        repeat (20) @(posedge dot_clk);
        count_window(64);
        check_count("R6 system blank ignored in VGA mode", s_edges, 16);

        // R6: system blank only sampled on falling VCLK; held VCLK freezes it
        vga_mode = 1'b0;
        sys_blank_n = 1'b1;
        cfg_write(8'h49);
        repeat (10) @(posedge dot_clk);
        cfg_write(8'h79);   // vclk held, rclk /2, sclk on
        repeat (5) @(posedge dot_clk);
        sys_blank_n = 1'b0;
        repeat (10) @(posedge dot_clk);
        count_window(64);
        check_count("R6 blank frozen while vclk held", s_edges, 32);
        cfg_write(8'h49);
        repeat (10) @(posedge dot_clk);
        count_window(64);
        check_count("R6 blank taken once vclk falls", s_edges, 0);
        sys_blank_n = 1'b1;

        finish_run();
    end

endmodule